// File: doc/BRIEF.md
# Complementary Mosaic Luma/Chroma Separator

This block sits right after the converter that digitises the output of a CCD with a yellow/cyan/magenta/green colour mosaic. Each line starts with a few optical-black pixels. The block averages them into a black reference and subtracts that reference from every later sample on the line. The corrected samples are then taken in consecutive pairs. Each pair gives one luminance value, which is half the pair's sum, and one colour-difference value, which is the second sample minus the first.

The mixed charge pairs change from line to line. On one kind of line the samples alternate (G+Cy), (Mg+Ye), so the difference is R-Y. On the other kind they alternate (Mg+Cy), (G+Ye), so the same subtraction gives -(B-Y). The block tags every output with the kind of line it came from. A line-type toggle is loaded from a configuration pin at each field start and flips at every other line start. This works the same way in both fields.

Samples enter on a valid/ready stream. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. The input is ready whenever the single output register is empty or is being drained. While `out_valid` is high and `out_ready` is low, the outputs hold steady and `in_ready` stays low.

Top module: `lcsep`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A sample flagged `in_sol` or `in_sof` starts a line. That sample and the next OB_PIX-1 accepted samples (3 in total by default) are black samples and produce no output. The black reference becomes floor(sum of those samples / OB_PIX).
- R3: Every later (active) sample on the line is corrected by subtracting the black reference of its line, as a signed value.
- R4: Active samples are grouped in consecutive pairs (1st,2nd), (3rd,4th) and so on. Each pair produces one output, loaded on the clock edge that accepts the pair's second sample.
- R5: `out_y` = floor((a+b)/2) of the corrected pair, clamped to the range 0 .. 2^DW-1.
- R6: `out_c` = b - a (second corrected sample minus first), two's complement, saturated to the signed CW-bit range (-512 .. 511 by default).
- R7: `out_ctype` is 0 for R-Y and 1 for -(B-Y). A line start that carries `in_sof` sets it to `cfg_first_type`. Any other line start inverts it.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_y`, `out_c` and `out_ctype` hold their values.
- R9: When a line start arrives after an odd number of active samples, the unpaired sample is dropped and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_first_type | input | 1 | Chroma type of the first line of each field |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | DW | Unsigned digitised CCD sample |
| in_sol | input | 1 | Sample is the first of a line |
| in_sof | input | 1 | Sample is the first of a field (also starts a line) |
| out_valid | output | 1 | Output pair result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_y | output | DW | Luminance, unsigned |
| out_c | output | CW | Colour difference, signed |
| out_ctype | output | 1 | 0 = R-Y, 1 = -(B-Y) |

## Verification
Each fault in the internal state shows at the ports on the very next pair of the line. A wrong black average offsets `out_y` but leaves `out_c` untouched. A pairing phase that is off by one sample swaps operands, which flips the sign of `out_c` and changes `out_y` at once. A line-type toggle that fails to reload at a field start, or that skips a flip, mislabels every pair of the affected line. A stalled output register that changes under back-pressure shows up on the next cycle that `out_ready` is held low.

// File: rtl/lcsep_pkg.sv
package lcsep_pkg;
  typedef enum logic {
    CT_R_MINUS_Y  = 1'b0,
    CT_NEG_B_MINUS_Y = 1'b1
  } ctype_e;
endpackage

// File: rtl/lcsep_black_ref.sv
// Per-line optical-black averager: marks black samples and holds the
// black reference for the rest of the line.
module lcsep_black_ref #(
  parameter int DW     = 10,
  parameter int OB_PIX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          line_start,
  input  logic [DW-1:0] data,
  output logic          is_ob,
  output logic [DW-1:0] black
);
  localparam int CNT_W = $clog2(OB_PIX + 1);
  localparam int ACC_W = DW + CNT_W;
  localparam logic [CNT_W-1:0] FIRST_LEFT = CNT_W'(OB_PIX - 1);
  localparam logic [ACC_W-1:0] DIVISOR    = ACC_W'(OB_PIX);

  logic [CNT_W-1:0] ob_left;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] sum_now;
  logic [ACC_W-1:0] avg_now;
  logic             last_ob;

  always_comb begin
    is_ob   = line_start || (ob_left != '0);
    sum_now = line_start ? ACC_W'(data) : acc_sum + ACC_W'(data);
    last_ob = line_start ? (OB_PIX == 1) : (ob_left == CNT_W'(1));
    avg_now = sum_now / DIVISOR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_left <= '0;
      acc_sum <= '0;
      black   <= '0;
    end else if (acc) begin
      if (line_start) begin
        ob_left <= FIRST_LEFT;
        acc_sum <= sum_now;
      end else if (ob_left != '0) begin
        ob_left <= ob_left - CNT_W'(1);
        acc_sum <= sum_now;
      end
      if (is_ob && last_ob) black <= avg_now[DW-1:0];
    end
  end
endmodule

// File: rtl/lcsep_line_phase.sv
// Line-type toggle and pair phase.
module lcsep_line_phase
  import lcsep_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   acc,
  input  logic   line_start,
  input  logic   field_start,
  input  logic   cfg_first,
  input  logic   active,
  output logic   second,
  output ctype_e ctype
);
  logic half;

  assign second = half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half  <= 1'b0;
      ctype <= CT_R_MINUS_Y;
    end else if (acc) begin
      if (line_start) begin
        half  <= 1'b0;
        ctype <= field_start ? ctype_e'(cfg_first) : ctype_e'(~ctype);
      end else if (active) begin
        half <= ~half;
      end
    end
  end
endmodule

// File: rtl/lcsep_pair_math.sv
// Sum/difference of a corrected pair with output saturation.
module lcsep_pair_math #(
  parameter int DW = 10,
  parameter int CW = 10
) (
  input  logic signed [DW:0]   a_corr,
  input  logic signed [DW:0]   b_corr,
  output logic        [DW-1:0] y,
  output logic signed [CW-1:0] c
);
  localparam int EW = DW + 2;
  localparam logic signed [EW-1:0] YMAX = EW'((1 << DW) - 1);
  localparam logic signed [EW-1:0] CMAX = EW'((1 << (CW - 1)) - 1);
  localparam logic signed [EW-1:0] CMIN = -CMAX - EW'(1);

  logic signed [EW-1:0] sum;
  logic signed [EW-1:0] half_sum;
  logic signed [EW-1:0] diff;

  always_comb begin
    sum      = EW'(a_corr) + EW'(b_corr);
    half_sum = sum >>> 1;
    diff     = EW'(b_corr) - EW'(a_corr);
    if (half_sum < 0)          y = '0;
    else if (half_sum > YMAX)  y = YMAX[DW-1:0];
    else                       y = half_sum[DW-1:0];
    if (diff > CMAX)           c = CMAX[CW-1:0];
    else if (diff < CMIN)      c = CMIN[CW-1:0];
    else                       c = diff[CW-1:0];
  end
endmodule

// File: rtl/lcsep.sv
module lcsep
  import lcsep_pkg::*;
#(
  parameter int DW     = 10,
  parameter int CW     = 10,
  parameter int OB_PIX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_first_type,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sol,
  input  logic          in_sof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_y,
  output logic [CW-1:0] out_c,
  output logic          out_ctype
);
  localparam int SW = DW + 1;

  logic                 acc;
  logic                 line_start;
  logic                 is_ob;
  logic                 active;
  logic                 second;
  logic                 emit;
  logic [DW-1:0]        black;
  ctype_e               ctype;
  logic signed [SW-1:0] corr;
  logic signed [SW-1:0] first_q;
  logic [DW-1:0]        y_d;
  logic signed [CW-1:0] c_d;

  assign in_ready   = !out_valid || out_ready;
  assign acc        = in_valid && in_ready;
  assign line_start = in_sol || in_sof;
  assign active     = acc && !is_ob;
  assign emit       = active && second;
  assign corr       = $signed({1'b0, in_data}) - $signed({1'b0, black});

  lcsep_black_ref #(.DW(DW), .OB_PIX(OB_PIX)) u_black (
    .clk(clk), .rst_n(rst_n), .acc(acc), .line_start(line_start),
    .data(in_data), .is_ob(is_ob), .black(black)
  );

  lcsep_line_phase u_phase (
    .clk(clk), .rst_n(rst_n), .acc(acc), .line_start(line_start),
    .field_start(in_sof), .cfg_first(cfg_first_type), .active(active),
    .second(second), .ctype(ctype)
  );

  lcsep_pair_math #(.DW(DW), .CW(CW)) u_math (
    .a_corr(first_q), .b_corr(corr), .y(y_d), .c(c_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= '0;
    else if (active && !second) first_q <= corr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c     <= '0;
      out_ctype <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_y     <= y_d;
      out_c     <= c_d;
      out_ctype <= ctype;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lcsep_chk.sv
module lcsep_chk #(
  parameter int DW     = 10,
  parameter int CW     = 10,
  parameter int OB_PIX = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_sol,
  input logic          in_sof,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_y,
  input logic [CW-1:0] out_c,
  input logic          out_ctype
);
  localparam int PW = $clog2(OB_PIX + 1) + 1;
  localparam logic [PW-1:0] OBL = PW'(OB_PIX);

  logic          take;
  logic          in_ob;
  logic [PW-1:0] seen;

  assign take  = in_valid && in_ready;
  assign in_ob = in_sol || in_sof || (seen != '0 && seen < OBL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (take) begin
      if (in_sol || in_sof) seen <= PW'(1);
      else if (seen != '0 && seen < OBL) seen <= seen + PW'(1);
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y) && $stable(out_c) && $stable(out_ctype)));

  // R8
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R4
  rose_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(take));

  // R2
  ob_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_ob && (!out_valid || out_ready)) |=> !out_valid);
endmodule

bind lcsep lcsep_chk #(.DW(DW), .CW(CW), .OB_PIX(OB_PIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sol(in_sol), .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
  .out_y(out_y), .out_c(out_c), .out_ctype(out_ctype)
);

// File: tb/lcsep_tb.sv
module lcsep_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // sof, cfg, ob0, ob1, ob2, a0, a1, a2, a3, y0, c0, y1, c1, type
  localparam int VEC [NV][14] = '{
    '{1, 0,   10,   20,   31,  120,  220,   50,  70,  150,  100,  40,   20, 0},
    '{0, 0,    0,    0,    0, 1000,   10,  500, 501,  505, -512, 500,    1, 1},
    '{0, 0,  100,  100,  100,   50,   60, 1023,1023,    0,   10, 923,    0, 0},
    '{1, 1,    3,    4,    5,    4, 1023,  900, 880,  509,  511, 886,  -20, 1},
    '{0, 1, 1023, 1023, 1023, 1023,    0,  200, 300,    0, -512,   0,  100, 0}
  };

  logic clk = 0, rst_n = 0, cfg_first_type = 0;
  logic in_valid = 0, in_sol = 0, in_sof = 0, out_ready = 1;
  logic [9:0] in_data = '0;
  logic in_ready, out_valid, out_ctype;
  logic [9:0] out_y, out_c;
  int checks = 0, fails = 0;
  int q_y[$], q_c[$], q_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcsep u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_first_type(cfg_first_type),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sol(in_sol), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_y(out_y), .out_c(out_c), .out_ctype(out_ctype)
  );

  always @(negedge clk) if (rst_n && out_valid && out_ready) begin
    q_y.push_back(int'(out_y));
    q_c.push_back(int'($signed(out_c)));
    q_t.push_back(int'(out_ctype));
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic sol, input logic sof, input int d);
    @(negedge clk);
    in_valid = 1; in_sol = sol; in_sof = sof; in_data = d[9:0];
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 0; in_sol = 0; in_sof = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic flush();
    q_y.delete(); q_c.delete(); q_t.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    rst_n = 1;

    // R2 R3 R4 R5 R6 R7: table walk, one line per entry
    for (int v = 0; v < NV; v++) begin
      flush();
      cfg_first_type = VEC[v][1][0];
      send(1'b1, VEC[v][0][0], VEC[v][2]);
      send(1'b0, 1'b0, VEC[v][3]);
      send(1'b0, 1'b0, VEC[v][4]);
      for (int k = 0; k < 4; k++) send(1'b0, 1'b0, VEC[v][5+k]);
      idle(3);
      check("R4 pair count", q_y.size(), 2);
      if (q_y.size() == 2) begin
        check("R5 y pair0 (R2 R3 black)", q_y[0], VEC[v][9]);
        check("R6 c pair0", q_c[0], VEC[v][10]);
        check("R5 y pair1", q_y[1], VEC[v][11]);
        check("R6 c pair1", q_c[1], VEC[v][12]);
        check("R7 type pair0", q_t[0], VEC[v][13]);
        check("R7 type pair1", q_t[1], VEC[v][13]);
      end
    end

    // R9: unpaired sample dropped at next line start
    flush();
    send(1'b1, 1'b0, 0); send(1'b0, 1'b0, 0); send(1'b0, 1'b0, 0);
    send(1'b0, 1'b0, 100);
    send(1'b1, 1'b0, 0); send(1'b0, 1'b0, 0); send(1'b0, 1'b0, 0);
    send(1'b0, 1'b0, 10); send(1'b0, 1'b0, 30);
    idle(3);
    check("R9 output count", q_y.size(), 1);
    if (q_y.size() == 1) begin
      check("R9 y", q_y[0], 20);
      check("R9 c", q_c[0], 20);
      check("R7 type after two toggles", q_t[0], 0);
    end

    // R8: back-pressure
    flush();
    out_ready = 0;
    send(1'b1, 1'b0, 0); send(1'b0, 1'b0, 0); send(1'b0, 1'b0, 0);
    send(1'b0, 1'b0, 40); send(1'b0, 1'b0, 60);
    @(negedge clk);
    in_valid = 1; in_sol = 0; in_sof = 0; in_data = 10'd500;
    check("R8 in_ready low", int'(in_ready), 0);
    check("R8 out_valid held", int'(out_valid), 1);
    repeat (4) @(negedge clk);
    check("R8 y held", int'(out_y), 50);
    check("R8 c held", int'($signed(out_c)), 20);
    check("R8 type held", int'(out_ctype), 1);
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    check("R8 drained", int'(out_valid), 0);
    check("R8 ready restored", int'(in_ready), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule